// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple host port and a four-bank, 16-bit, single-data-rate SDRAM. It has 12 row bits and 9 column bits. After reset it waits a programmable power-up time. It then brings the memory up by precharging every bank, issuing two auto refreshes and writing the mode word. Once that is done, it accepts one host access at a time. Each access becomes a bank activate followed by a read or write that carries the auto-precharge flag, so every row is closed again by the memory itself. All minimum spacings are parameters counted in clock cycles.

A free-running timer raises a refresh request every `CLK_MHZ*156/10` cycles, which is about 15.6 µs at any clock rate. The sequencer serves a due refresh before the next host access, but only after the current access has run its full activate-to-reopen window.

On the host port, a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle and no refresh is due, so the host must hold the request and its fields steady until it is taken. Read data comes back on `rd_valid`/`rd_data` with no back-pressure: one beat per cycle, `BURST_LEN` beats per read.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, and for at least `INIT_WAIT` cycles after it is released, the memory pins carry only no-operation, and `req_ready` and `rd_valid` stay low.
- R2: The start-up commands, in order, are: precharge with address bit 10 high (all banks), auto refresh, auto refresh, mode register set. No host access runs before the mode register set.
- R3: Start-up spacing is at least `T_RP` cycles after the precharge, `T_RC` after each refresh, and `T_MRD` from the mode register set to the first activate.
- R4: The mode word has bits 2:0 = log2(`BURST_LEN`), bit 3 = 0 (sequential), bits 6:4 = `CAS_LAT`, bit 9 = 1 (writes touch a single location), and every other bit 0.
- R5: Commands use {cs_n, ras_n, cas_n, we_n} as follows: 0000 mode set, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0111 no-op. Burst stop (0110) is never issued.
- R6: For a request address, bits 22:21 drive the bank pins. Bits 20:9 are the row, sent on activate. Bits 8:0 are the column, sent on read or write with address bit 10 forced high to request auto precharge.
- R7: `req_ready` is high only when the sequencer is idle and no refresh is due. It falls in the cycle after a request is taken. Each request taken produces exactly one activate.
- R8: A write drives `sd_dq_oe` high only in the write command cycle, with `sd_dq_out` equal to the write data and `sd_dqm[i]` equal to the inverse of `req_wmask[i]`. Bytes whose mask bit is 0 keep their old contents.
- R9: After a read command sampled at edge n, `rd_valid` is high after edges n+`CAS_LAT` through n+`CAS_LAT`+`BURST_LEN`-1. Each beat holds the DQ value sampled at that edge, and the columns wrap within the aligned burst block in sequential order.
- R10: On any bank: activate to read or write is at least `T_RCD`, activate to activate is at least `T_RC`, and activate to the start of the internal precharge is at least `T_RAS`. The bank reopens no earlier than `T_RP` after that precharge starts. No bank is activated twice without being closed in between.
- R11: During normal operation, each auto refresh finds every bank closed and ready, nothing follows it for `T_RC` cycles, and over an idle span of ten refresh periods there are 9 to 11 refreshes.
- R12: A due refresh is served before any waiting host request. Under continuous host traffic, no gap between refreshes exceeds the refresh period by more than 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Bank, row, column |
| req_wdata | input | 16 | Write data |
| req_wmask | input | 2 | Byte enables, 1 = write that byte |
| rd_valid | output | 1 | Read beat present |
| rd_data | output | 16 | Read beat |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed address |
| sd_dqm | output | 2 | Byte mask, high blocks |
| sd_dq_out | output | 16 | Data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The assertions assume that reset is held low through the first clock edges. They also assume the default parameter ordering, with `T_RCD` of at least two cycles, so that an activate is always followed by a quiet cycle. The stimulus meets these assumptions directly, and it holds every request steady until the handshake completes. The bench's memory model returns data exactly `CAS_LAT` edges after a read and records every spacing violation against the bank it concerns. The bench sweeps all four banks across edge rows and columns and all four byte masks, then leaves the port idle so that refresh pacing can be measured.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_REFR = 4'b0001,
    CMD_PRCH = 4'b0010,
    CMD_ACTV = 4'b0011,
    CMD_WRIT = 4'b0100,
    CMD_READ = 4'b0101,
    CMD_STOP = 4'b0110,
    CMD_NOP  = 4'b0111,
    CMD_DSEL = 4'b1111
  } sd_cmd_t;

  typedef enum logic [3:0] {
    ST_POWER, ST_PALL, ST_IREF, ST_MODE, ST_IDLE,
    ST_REFR, ST_ACTV, ST_XFER, ST_WAIT
  } seq_state_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic due
);
  localparam int unsigned W = $clog2(PERIOD + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= W'(PERIOD - 1);
      due <= 1'b0;
    end else if (cnt == '0) begin
      cnt <= W'(PERIOD - 1);
      due <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
      if (ack) due <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int unsigned CAS_LAT   = 3,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_issue,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned BW = $clog2(BURST_LEN + 1);

  logic          start;
  logic [BW-1:0] left;

  generate
    if (CAS_LAT > 1) begin : g_pipe
      logic [CAS_LAT-1:0] pipe;
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[CAS_LAT-2:0], rd_issue};
      end
      assign start = pipe[CAS_LAT-1];
    end else begin : g_one
      logic pipe1;
      always_ff @(posedge clk) begin
        if (!rst_n) pipe1 <= 1'b0;
        else        pipe1 <= rd_issue;
      end
      assign start = pipe1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= start || (left != '0);
      rd_data  <= dq_in;
      if (start)            left <= BW'(BURST_LEN - 1);
      else if (left != '0)  left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int unsigned INIT_WAIT = 20000,
  parameter int unsigned CAS_LAT   = 3,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 5,
  parameter int unsigned T_RC      = 8,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_WR      = 1,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned DW        = 16,
  localparam int unsigned AW       = BANK_W + ROW_W + COL_W,
  localparam int unsigned MW       = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_due,
  output logic              ref_ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [MW-1:0]     req_wmask,
  output sd_cmd_t           cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic [MW-1:0]     dqm,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic              rd_issue
);
  localparam int unsigned RD_GAP = umax(umax(CAS_LAT + BURST_LEN, BURST_LEN + T_RP),
                                        umax(T_RC - T_RCD, T_RAS - T_RCD + T_RP));
  localparam int unsigned WR_GAP = umax(T_WR + T_RP, umax(T_RC - T_RCD, T_RAS - T_RCD + T_RP));
  localparam int unsigned CW     = $clog2(umax(INIT_WAIT, 64) + 1);
  localparam int unsigned BLC    = $clog2(BURST_LEN);
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((1 << 9) | (CAS_LAT << 4) | BLC);

  seq_state_t        st, nxt;
  logic [CW-1:0]     cnt;
  logic              second_ref;
  logic              l_write;
  logic [BANK_W-1:0] l_bank;
  logic [ROW_W-1:0]  l_row;
  logic [COL_W-1:0]  l_col;
  logic [DW-1:0]     l_wdata;
  logic [MW-1:0]     l_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_POWER;
      nxt        <= ST_IDLE;
      cnt        <= CW'(INIT_WAIT);
      second_ref <= 1'b0;
      l_write    <= 1'b0;
      l_bank     <= '0;
      l_row      <= '0;
      l_col      <= '0;
      l_wdata    <= '0;
      l_mask     <= '0;
    end else begin
      case (st)
        ST_POWER: if (cnt == '0) st <= ST_PALL; else cnt <= cnt - 1'b1;
        ST_PALL: begin st <= ST_WAIT; nxt <= ST_IREF; cnt <= CW'(T_RP - 2); end
        ST_IREF: begin
          st         <= ST_WAIT;
          nxt        <= second_ref ? ST_MODE : ST_IREF;
          second_ref <= 1'b1;
          cnt        <= CW'(T_RC - 2);
        end
        ST_MODE: begin st <= ST_WAIT; nxt <= ST_IDLE; cnt <= CW'(T_MRD - 2); end
        ST_IDLE: begin
          if (ref_due) st <= ST_REFR;
          else if (req_valid) begin
            st      <= ST_ACTV;
            l_write <= req_write;
            l_bank  <= req_addr[AW-1 -: BANK_W];
            l_row   <= req_addr[COL_W +: ROW_W];
            l_col   <= req_addr[COL_W-1:0];
            l_wdata <= req_wdata;
            l_mask  <= req_wmask;
          end
        end
        ST_REFR: begin st <= ST_WAIT; nxt <= ST_IDLE; cnt <= CW'(T_RC - 2); end
        ST_ACTV: begin st <= ST_WAIT; nxt <= ST_XFER; cnt <= CW'(T_RCD - 2); end
        ST_XFER: begin
          st  <= ST_WAIT;
          nxt <= ST_IDLE;
          cnt <= l_write ? CW'(WR_GAP - 2) : CW'(RD_GAP - 2);
        end
        ST_WAIT: if (cnt == '0) st <= nxt; else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd      = CMD_NOP;
    ba       = '0;
    addr     = '0;
    dqm      = '0;
    dq_out   = '0;
    dq_oe    = 1'b0;
    rd_issue = 1'b0;
    case (st)
      ST_PALL: begin cmd = CMD_PRCH; addr[10] = 1'b1; end
      ST_IREF, ST_REFR: cmd = CMD_REFR;
      ST_MODE: begin cmd = CMD_MODE; addr = MODE_WORD; end
      ST_ACTV: begin cmd = CMD_ACTV; ba = l_bank; addr = l_row; end
      ST_XFER: begin
        ba       = l_bank;
        addr     = ROW_W'(l_col);
        addr[10] = 1'b1;
        if (l_write) begin
          cmd    = CMD_WRIT;
          dq_oe  = 1'b1;
          dq_out = l_wdata;
          dqm    = ~l_mask;
        end else begin
          cmd      = CMD_READ;
          rd_issue = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign req_ready = (st == ST_IDLE) && !ref_due;
  assign ref_ack   = (st == ST_REFR);
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned INIT_WAIT = 20000,
  parameter int unsigned CAS_LAT   = 3,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 5,
  parameter int unsigned T_RC      = 8,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_WR      = 1,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned DW        = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]  req_addr,
  input  logic [DW-1:0]                  req_wdata,
  input  logic [DW/8-1:0]                req_wmask,
  output logic                           rd_valid,
  output logic [DW-1:0]                  rd_data,
  output logic                           sd_cs_n,
  output logic                           sd_ras_n,
  output logic                           sd_cas_n,
  output logic                           sd_we_n,
  output logic [BANK_W-1:0]              sd_ba,
  output logic [ROW_W-1:0]               sd_addr,
  output logic [DW/8-1:0]                sd_dqm,
  output logic [DW-1:0]                  sd_dq_out,
  output logic                           sd_dq_oe,
  input  logic [DW-1:0]                  sd_dq_in
);
  localparam int unsigned REF_PERIOD = CLK_MHZ * 156 / 10;

  logic    ref_due, ref_ack, rd_issue;
  sd_cmd_t cmd;

  sdram_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .due(ref_due)
  );

  sdram_cmd_fsm #(
    .INIT_WAIT(INIT_WAIT), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_MRD(T_MRD), .T_WR(T_WR), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .DW(DW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .ref_due(ref_due), .ref_ack(ref_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .cmd(cmd), .ba(sd_ba), .addr(sd_addr), .dqm(sd_dqm),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe), .rd_issue(rd_issue)
  );

  sdram_rd_capture #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk #(
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned CAS_LAT   = 3,
  parameter int unsigned ROW_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [ROW_W-1:0] sd_addr,
  input logic             sd_dq_oe,
  input logic             req_valid,
  input logic             req_ready
);
  localparam logic [ROW_W-1:0] EXP_MODE = ROW_W'((1 << 9) | (CAS_LAT << 4) | $clog2(BURST_LEN));

  logic [3:0] pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  p_autopre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0100 || pins == 4'b0101) |-> sd_addr[10]);

  p_oe_only_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (pins == 4'b0100));

  p_ready_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (pins == 4'b0111));

  p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_act_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0011) |=> (pins == 4'b0111));

  p_mode_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (sd_addr == EXP_MODE));

  p_no_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pins != 4'b0110);
endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(
  .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
  .sd_dq_oe(sd_dq_oe), .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/sim_sdram_seq_ctrl.sv
module sim_sdram_seq_ctrl;
  localparam int PERIOD = 10;
  localparam int CL = 3, BL = 4, INITW = 10, MHZ = 4, REFP = MHZ * 156 / 10;
  localparam int TRCD = 3, TRP = 3, TRAS = 5, TRC = 8, TMRD = 2, TWR = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_wmask = '0;
  logic req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out, sd_dq_in;
  logic [1:0] sd_ba, sd_dqm;
  logic [11:0] sd_addr;

  always #(PERIOD / 2) clk = ~clk;

  sdram_seq_ctrl #(.CLK_MHZ(MHZ), .INIT_WAIT(INITW), .CAS_LAT(CL), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wmask(req_wmask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] bg(input logic [22:0] k);
    return k[15:0] ^ {k[22:16], k[8:0]} ^ 16'h5A5A;
  endfunction

  // ---------------- memory model ----------------
  logic [15:0] mem [int];
  logic [15:0] sched [64];
  bit vsched [64];
  int ecnt = 0, rel_edge = -1, first_act = -1, busy = 0, act_cnt = 0;
  bit busy_init = 0, mrs_seen = 0;
  int open_b [4], act_t [4], rdy_t [4], last_act [4];
  int init_n = 0;
  logic [3:0] init_c [4];
  bit init_a10 [4];
  int init_e [4];
  logic [11:0] mrs_word;
  int ref_cnt = 0, last_ref = -1, max_gap = 0;
  int v_r3 = 0, v_r5 = 0, v_r6 = 0, v_r8 = 0, v_r10 = 0, v_r11 = 0, v_r7 = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin
      open_b[i] = 0; act_t[i] = -1000; rdy_t[i] = 0; last_act[i] = -1000;
    end
    for (int i = 0; i < 64; i++) begin sched[i] = '0; vsched[i] = 0; end
    sd_dq_in = '0;
  end

  logic [3:0] c;
  int b, pre;
  logic [22:0] k;
  logic [15:0] old;

  always @(posedge clk) begin
    ecnt = ecnt + 1;
    if (rst_n) begin
      if (rel_edge < 0) rel_edge = ecnt;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      b = int'(sd_ba);
      if ($isunknown(c)) v_r5++;
      else if (!sd_cs_n && c != 4'b0111) begin
        if (ecnt < busy) begin if (busy_init) v_r3++; else v_r11++; end
        if (init_n < 4) begin
          init_c[init_n] = c; init_a10[init_n] = sd_addr[10]; init_e[init_n] = ecnt; init_n++;
        end
        if (sd_dq_oe && c != 4'b0100) v_r8++;
        case (c)
          4'b0010: begin
            if (mrs_seen || !sd_addr[10]) v_r5++;
            for (int i = 0; i < 4; i++) begin open_b[i] = 0; rdy_t[i] = ecnt + TRP; end
          end
          4'b0001: begin
            for (int i = 0; i < 4; i++)
              if (open_b[i] != 0 || ecnt < rdy_t[i]) begin if (mrs_seen) v_r11++; else v_r3++; end
            busy = ecnt + TRC; busy_init = !mrs_seen;
            if (mrs_seen) begin
              ref_cnt++;
              if (last_ref >= 0 && ecnt - last_ref > max_gap) max_gap = ecnt - last_ref;
              last_ref = ecnt;
            end
          end
          4'b0000: begin
            for (int i = 0; i < 4; i++) if (open_b[i] != 0 || ecnt < rdy_t[i]) v_r3++;
            busy = ecnt + TMRD; busy_init = 1; mrs_word = sd_addr; mrs_seen = 1;
          end
          4'b0011: begin
            if (!mrs_seen) v_r3++;
            if (first_act < 0) first_act = ecnt;
            if (open_b[b] != 0 || ecnt < rdy_t[b] || ecnt - last_act[b] < TRC) v_r10++;
            open_b[b] = 1; act_t[b] = ecnt; last_act[b] = ecnt; act_cnt++;
          end
          4'b0100, 4'b0101: begin
            if (open_b[b] == 0 || ecnt - act_t[b] < TRCD) v_r10++;
            if (!sd_addr[10]) v_r6++;
            if (c == 4'b0100) begin
              if (!sd_dq_oe) v_r8++;
              k = {sd_ba, 12'(act_row(b)), sd_addr[8:0]};
              old = mem.exists(int'(k)) ? mem[int'(k)] : bg(k);
              mem[int'(k)] = {sd_dqm[1] ? old[15:8] : sd_dq_out[15:8],
                              sd_dqm[0] ? old[7:0]  : sd_dq_out[7:0]};
              pre = ecnt + TWR;
            end else begin
              for (int j = 0; j < BL; j++) begin
                k = {sd_ba, 12'(act_row(b)),
                     sd_addr[8:0] & 9'(~(BL - 1)) | 9'((int'(sd_addr[8:0]) + j) & (BL - 1))};
                sched[(ecnt + CL + j) % 64] = mem.exists(int'(k)) ? mem[int'(k)] : bg(k);
                vsched[(ecnt + CL + j) % 64] = 1;
              end
              pre = ecnt + BL;
            end
            if (pre < act_t[b] + TRAS) pre = act_t[b] + TRAS;
            rdy_t[b] = pre + TRP; open_b[b] = 0;
          end
          default: v_r5++;
        endcase
      end
    end
    sd_dq_in <= #1 sched[(ecnt + 1) % 64];
  end

  // row latched at activate, per bank
  logic [11:0] row_of [4];
  always @(posedge clk)
    if (rst_n && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011) row_of[sd_ba] <= sd_addr;
  function automatic int act_row(input int bk);
    return int'(row_of[bk]);
  endfunction

  // ---------------- host side ----------------
  logic [15:0] shadow [int];
  logic [15:0] expq [$];
  int hs_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !mrs_seen && req_ready) v_r7++;
    if (rst_n) begin
      bit ev;
      ev = vsched[ecnt % 64];
      vsched[ecnt % 64] = 0;
      if (ev || rd_valid) chk(rd_valid == ev, "R9 beat timing", rd_valid, ev);
      if (rd_valid) begin
        if (expq.size() == 0) chk(0, "R9 unexpected beat", rd_data, 0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk(rd_data == e, "R6 R8 R9 read data", rd_data, e);
        end
      end
    end
  end

  function automatic logic [15:0] cur(input logic [22:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : bg(a);
  endfunction

  task automatic host(input bit wr, input logic [22:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] o;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_wmask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    hs_cnt++;
    if (wr) begin
      o = cur(a);
      shadow[int'(a)] = {m[1] ? d[15:8] : o[15:8], m[0] ? d[7:0] : o[7:0]};
    end else begin
      for (int j = 0; j < BL; j++)
        expq.push_back(cur({a[22:9], (a[8:0] & 9'(~(BL - 1))) | 9'((int'(a[8:0]) + j) & (BL - 1))}));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [11:0] rows [3];
    logic [8:0] cols [3];
    logic [22:0] a;
    int r0;
    rows[0] = 12'h000; rows[1] = 12'h5A5; rows[2] = 12'hFFF;
    cols[0] = 9'd0; cols[1] = 9'd6; cols[2] = 9'd511;

    repeat (4) @(negedge clk);
    chk(req_ready == 0 && rd_valid == 0, "R1 outputs in reset", {req_ready, rd_valid}, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 pins in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    rst_n = 1;
    while (!mrs_seen) @(negedge clk);

    chk(init_e[0] - rel_edge >= INITW, "R1 power-up wait", init_e[0] - rel_edge, INITW);
    chk(init_c[0] == 4'b0010 && init_a10[0], "R2 first is precharge all", {init_c[0], init_a10[0]}, 5'b00101);
    chk(init_c[1] == 4'b0001, "R2 second is refresh", init_c[1], 1);
    chk(init_c[2] == 4'b0001, "R2 third is refresh", init_c[2], 1);
    chk(init_c[3] == 4'b0000, "R2 fourth is mode set", init_c[3], 0);
    chk(init_e[1] - init_e[0] >= TRP && init_e[2] - init_e[1] >= TRC && init_e[3] - init_e[2] >= TRC,
        "R3 init spacing", init_e[3] - init_e[0], TRP + 2 * TRC);
    chk(mrs_word == 12'((1 << 9) | (CL << 4) | 2), "R4 mode word", mrs_word, (1 << 9) | (CL << 4) | 2);

    for (int bk = 0; bk < 4; bk++)
      for (int ri = 0; ri < 3; ri++)
        for (int ci = 0; ci < 3; ci++)
          host(1, {2'(bk), rows[ri], cols[ci]}, 16'(bk * 4096 + ri * 256 + ci * 16 + 7) ^ 16'hC33C, 2'b11);
    for (int bk = 0; bk < 4; bk++)
      for (int ri = 0; ri < 3; ri++)
        for (int ci = 0; ci < 3; ci++)
          host(0, {2'(bk), rows[ri], cols[ci]}, 16'h0, 2'b00);

    a = {2'd2, 12'h123, 9'd45};
    for (int m = 0; m < 4; m++) begin
      host(1, a, 16'h1234 + 16'(m * 16'h1111), 2'(m));
      host(0, a, 16'h0, 2'b00);
    end
    host(0, {2'd3, 12'h777, 9'd130}, 16'h0, 2'b00);

    repeat (30) @(negedge clk);
    chk(first_act - init_e[3] >= TMRD, "R3 mode set to first activate", first_act - init_e[3], TMRD);
    chk(max_gap <= REFP + 16 && max_gap > 0, "R12 refresh gap under traffic", max_gap, REFP + 16);

    r0 = ref_cnt;
    repeat (10 * REFP) @(negedge clk);
    chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R11 refresh count idle", ref_cnt - r0, 10);

    chk(hs_cnt == act_cnt, "R7 one activate per request", act_cnt, hs_cnt);
    chk(v_r7 == 0, "R7 ready during start-up", v_r7, 0);
    chk(v_r3 == 0, "R3 start-up timing", v_r3, 0);
    chk(v_r5 == 0, "R5 command set", v_r5, 0);
    chk(v_r6 == 0, "R6 auto-precharge bit", v_r6, 0);
    chk(v_r8 == 0, "R8 output enable", v_r8, 0);
    chk(v_r10 == 0, "R10 bank timing", v_r10, 0);
    chk(v_r11 == 0, "R11 refresh timing", v_r11, 0);
    chk(expq.size() == 0, "R9 all beats returned", expq.size(), 0);
    finish_run();
  end
endmodule